// File: doc/BRIEF.md
# Frequency and Period Measurement Counter

This block measures a signal in one of two ways with a single saturating counter. In frequency mode it counts rising edges of a chosen input (a high-range or a low-range signal, both already conditioned to logic levels) during a fixed gate window of 1, 4, 8 or 32 ms. In period mode it counts cycles of the block clock, used as the reference, from one rising edge of the low-range input to the next; this mode is tied to the low-range input whatever input is selected.

Software-facing control is kept to a configuration write strobe (mode, input and gate choice), a start pulse and a clear pulse. The block reports busy and done, an overflow flag that is raised when the counter is pinned at its maximum, and the live count. The counter width defaults to 20 bits and the number of clock cycles per millisecond is a parameter.

Top module: `freq_period_counter`

## Requirements
- R1: After reset busy, done and overflow are 0, the result is 0, and the stored configuration selects frequency mode, the high-range input and the 1 ms gate.
- R2: In frequency mode a start pulse while idle raises busy on the next clock; busy stays high for exactly the gate length in cycles, then done rises; the result equals the number of rising edges of the selected input seen while busy.
- R3: The gate code sets the gate length: code 0 gives 1 ms, code 1 gives 4 ms, code 2 gives 8 ms, code 3 gives 32 ms, where 1 ms is TICKS_PER_MS clock cycles.
- R4: In frequency mode the input select bit picks the high-range input when 0 and the low-range input when 1; edges on the other input are not counted.
- R5: In period mode (mode bit 1) the block waits for a rising edge of the low-range input, then the result is the number of clock cycles until the next rising edge of that input, after which busy falls and done rises; the input select bit and the high-range input have no effect.
- R6: The count never wraps: an increment at all ones leaves the result at all ones and sets the overflow flag, which stays set until the next start or clear.
- R7: A clear pulse on the next clock sets the result to 0, drops busy, done and overflow, and aborts a running measurement; clear wins over start.
- R8: A start pulse while busy is ignored: the running measurement keeps its gate, its count and its end time.
- R9: A configuration write while busy is ignored; the stored configuration is unchanged for later runs.
- R10: A start while idle clears done, overflow and the result on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the period reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| hi_in | input | 1 | High-range measured input |
| lo_in | input | 1 | Low-range measured input |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_period | input | 1 | 1 selects period mode, 0 frequency mode |
| cfg_lo | input | 1 | 1 selects the low-range input in frequency mode |
| cfg_gate | input | 2 | Gate code, 0..3 for 1, 4, 8, 32 ms |
| start | input | 1 | Start pulse |
| clear | input | 1 | Clear pulse |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Measurement finished |
| overflow | output | 1 | Counter pinned at all ones |
| result | output | CNT_W | Count value |

## Verification
Every cycle the assertions watch that busy and done are never high together, that an overflow always coincides with an all-ones result and persists until start or clear, that clear empties the block one cycle later, that a start during a run never shrinks the count, and that a frequency run never outlasts the longest gate. Only the bench scenarios can show the exact edge counts, the gate length for each code, which input is counted, the measured period, and that writes and starts during a run leave later runs unchanged.

// File: rtl/freq_period_counter.sv
module freq_period_counter #(
  parameter int CNT_W        = 20,
  parameter int TICKS_PER_MS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hi_in,
  input  logic             lo_in,
  input  logic             cfg_we,
  input  logic             cfg_period,
  input  logic             cfg_lo,
  input  logic [1:0]       cfg_gate,
  input  logic             start,
  input  logic             clear,
  output logic             busy,
  output logic             done,
  output logic             overflow,
  output logic [CNT_W-1:0] result
);
  localparam int GATE_MAX = 32 * TICKS_PER_MS;
  localparam int GW       = $clog2(GATE_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0]    hi_sh, lo_sh;
  logic          hi_rise, lo_rise, sel_rise, bump, go;
  logic          mode_q, sel_q, armed;
  logic [1:0]    gate_q;
  logic [GW-1:0] gate_cnt, gate_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_sh <= '0;
      lo_sh <= '0;
    end else begin
      hi_sh <= {hi_sh[1:0], hi_in};
      lo_sh <= {lo_sh[1:0], lo_in};
    end
  end

  assign hi_rise  = hi_sh[1] & ~hi_sh[2];
  assign lo_rise  = lo_sh[1] & ~lo_sh[2];
  assign sel_rise = sel_q ? lo_rise : hi_rise;
  assign go       = start & ~busy;

  always_comb begin
    case (gate_q)
      2'd0:    gate_len = GW'(TICKS_PER_MS);
      2'd1:    gate_len = GW'(4 * TICKS_PER_MS);
      2'd2:    gate_len = GW'(8 * TICKS_PER_MS);
      default: gate_len = GW'(GATE_MAX);
    endcase
  end

  assign bump = mode_q ? armed : sel_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      sel_q    <= 1'b0;
      gate_q   <= 2'd0;
      busy     <= 1'b0;
      done     <= 1'b0;
      overflow <= 1'b0;
      armed    <= 1'b0;
      result   <= '0;
      gate_cnt <= '0;
    end else if (clear) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      overflow <= 1'b0;
      armed    <= 1'b0;
      result   <= '0;
    end else begin
      if (cfg_we && !busy) begin
        mode_q <= cfg_period;
        sel_q  <= cfg_lo;
        gate_q <= cfg_gate;
      end
      if (go) begin
        busy     <= 1'b1;
        done     <= 1'b0;
        overflow <= 1'b0;
        armed    <= 1'b0;
        result   <= '0;
        gate_cnt <= gate_len - 1'b1;
      end else if (busy) begin
        if (bump) begin
          if (result == CNT_MAX) overflow <= 1'b1;
          else                   result   <= result + 1'b1;
        end
        if (!mode_q) begin
          if (gate_cnt == '0) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            gate_cnt <= gate_cnt - 1'b1;
          end
        end else if (lo_rise) begin
          if (!armed) begin
            armed <= 1'b1;
          end else begin
            armed <= 1'b0;
            busy  <= 1'b0;
            done  <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/freq_period_counter_chk.sv
module freq_period_counter_chk #(
  parameter int CNT_W        = 20,
  parameter int TICKS_PER_MS = 1000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             clear,
  input logic             busy,
  input logic             done,
  input logic             overflow,
  input logic             mode_q,
  input logic [CNT_W-1:0] result
);
  localparam int GATE_MAX = 32 * TICKS_PER_MS;
  localparam int RW       = $clog2(GATE_MAX + 2);

  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run <= '0;
    else if (!busy)              run <= '0;
    else if (run != RW'(GATE_MAX + 1)) run <= run + 1'b1;
  end

  p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_gate_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q) |-> (run < RW'(GATE_MAX)));

  p_saturated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (result == {CNT_W{1'b1}}));

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clear && !(start && !busy)) |=> overflow);

  p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!busy && !done && !overflow && result == '0));

  p_start_in_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !clear && result != '0) |=> (result != '0));

  p_start_resets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !clear) |=> (busy && !done && !overflow && result == '0));
endmodule

bind freq_period_counter freq_period_counter_chk #(
  .CNT_W(CNT_W), .TICKS_PER_MS(TICKS_PER_MS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .clear(clear), .busy(busy),
  .done(done), .overflow(overflow), .mode_q(mode_q), .result(result)
);

// File: tb/freq_period_counter_tb.sv
module freq_period_counter_tb;
  localparam int W   = 10;
  localparam int TPM = 40;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 0, rst_n = 0;
  logic hi_in = 0, lo_in = 0, cfg_we = 0, cfg_period = 0, cfg_lo = 0;
  logic [1:0] cfg_gate = 0;
  logic start = 0, clear = 0;
  logic busy, done, overflow;
  logic [W-1:0] result;

  int checks = 0, errors = 0;
  int exp_q[$];
  int len_q[$];
  string tag_q[$];
  int cur_len = 0;
  logic busy_d = 0, done_d = 0;

  always #4 clk = ~clk;

  freq_period_counter #(.CNT_W(W), .TICKS_PER_MS(TPM)) u_dut (
    .clk(clk), .rst_n(rst_n), .hi_in(hi_in), .lo_in(lo_in), .cfg_we(cfg_we),
    .cfg_period(cfg_period), .cfg_lo(cfg_lo), .cfg_gate(cfg_gate),
    .start(start), .clear(clear), .busy(busy), .done(done),
    .overflow(overflow), .result(result));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops expectations on each completed measurement
  always @(negedge clk) begin
    if (busy && !busy_d) cur_len = 0;
    if (busy) cur_len++;
    if (done && !done_d) begin
      if (exp_q.size() == 0) begin
        check("unexpected done", 1, 0);
      end else begin
        automatic int e = exp_q.pop_front();
        automatic int l = len_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, int'({overflow, result}), e);
        if (l >= 0) check({t, " gate length"}, cur_len, l);
      end
    end
    busy_d = busy;
    done_d = done;
  end

  task automatic write_cfg(input logic per, input logic lo, input logic [1:0] g);
    @(negedge clk);
    cfg_we = 1; cfg_period = per; cfg_lo = lo; cfg_gate = g;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      if (done) return;
      @(negedge clk);
    end
    check("timeout waiting for done", 0, 1);
  endtask

  function automatic int glen(input int g);
    return g == 0 ? TPM : g == 1 ? 4*TPM : g == 2 ? 8*TPM : 32*TPM;
  endfunction

  // drive nh pulses on hi and nl on lo, 4 cycles each
  task automatic pulses(input int nh, input int nl);
    for (int i = 0; i < (nh > nl ? nh : nl); i++) begin
      hi_in = (i < nh); lo_in = (i < nl);
      repeat (2) @(negedge clk);
      hi_in = 0; lo_in = 0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic freq_run(input string t, input logic lo, input int g, input int nh, input int nl);
    exp_q.push_back(lo ? nl : nh); len_q.push_back(glen(g)); tag_q.push_back(t);
    pulse_start();
    repeat (2) @(negedge clk);
    pulses(nh, nl);
    wait_done();
  endtask

  task automatic period_run(input string t, input int p, input bit noise, input bit mid_start);
    exp_q.push_back(p > MAXV ? ((1 << W) | MAXV) : p);
    len_q.push_back(-1); tag_q.push_back(t);
    pulse_start();
    repeat (3) @(negedge clk);
    lo_in = 1; repeat (2) @(negedge clk);
    lo_in = 0;
    for (int i = 0; i < p - 2; i++) begin
      if (noise) hi_in = (i % 4) < 2;
      if (mid_start && i == 3) start = 1;
      else start = 0;
      @(negedge clk);
    end
    start = 0; hi_in = 0;
    lo_in = 1; repeat (2) @(negedge clk);
    lo_in = 0;
    wait_done();
  endtask

  initial begin
    #(200000 * 8);
    check("watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 done after reset", done, 0);
    check("R1 overflow after reset", overflow, 0);
    check("R1 result after reset", result, 0);

    // R1 default config: frequency, high input, 1 ms
    freq_run("R1 R2 default config counts hi", 0, 0, 5, 2);
    // R4 low input selected
    write_cfg(0, 1, 1);
    freq_run("R3 R4 lo input 4ms gate", 1, 1, 3, 6);
    write_cfg(0, 0, 2);
    freq_run("R3 hi input 8ms gate", 0, 2, 7, 1);
    write_cfg(0, 0, 3);
    freq_run("R3 hi input 32ms gate", 0, 3, 0, 4);

    // R8 start while busy in frequency mode
    write_cfg(0, 0, 0);
    exp_q.push_back(4); len_q.push_back(TPM); tag_q.push_back("R8 start in freq run");
    pulse_start();
    repeat (2) @(negedge clk);
    pulses(2, 0);
    start = 1; @(negedge clk); start = 0;
    pulses(2, 0);
    wait_done();

    // R9 config write during run ignored
    exp_q.push_back(3); len_q.push_back(TPM); tag_q.push_back("R9 run with write mid-run");
    pulse_start();
    repeat (2) @(negedge clk);
    pulses(3, 0);
    cfg_we = 1; cfg_period = 1; cfg_lo = 1; cfg_gate = 3;
    @(negedge clk); cfg_we = 0;
    wait_done();
    freq_run("R9 config unchanged afterwards", 0, 0, 2, 5);

    // R5 period mode, select bit 0 ignored, hi noise ignored
    write_cfg(1, 0, 0);
    period_run("R5 period 37 cycles", 37, 1, 0);
    write_cfg(1, 1, 2);
    period_run("R5 period 150 cycles", 150, 0, 0);
    period_run("R8 start in period run", 60, 0, 1);

    // R6 saturation
    period_run("R6 period overflow", 1100, 0, 0);
    check("R6 overflow held after done", overflow, 1);
    check("R6 result pinned", result, MAXV);

    // R10 next start clears flags
    pulse_start();
    check("R10 overflow cleared by start", overflow, 0);
    check("R10 done cleared by start", done, 0);
    check("R10 result cleared by start", result, 0);
    exp_q.push_back(20); len_q.push_back(-1); tag_q.push_back("R5 R10 period after overflow");
    repeat (3) @(negedge clk);
    lo_in = 1; repeat (2) @(negedge clk); lo_in = 0;
    repeat (18) @(negedge clk);
    lo_in = 1; repeat (2) @(negedge clk); lo_in = 0;
    wait_done();

    // R7 clear aborts a run
    write_cfg(0, 0, 3);
    pulse_start();
    repeat (2) @(negedge clk);
    pulses(3, 0);
    check("R7 partial count before clear", result, 3);
    clear = 1; start = 1; @(negedge clk); clear = 0; start = 0;
    check("R7 busy after clear", busy, 0);
    check("R7 result after clear", result, 0);
    check("R7 done after clear", done, 0);
    repeat (10) @(negedge clk);
    check("R7 stays idle after clear", busy, 0);

    // R7 clear after completed overflow run
    write_cfg(1, 0, 0);
    period_run("R6 second overflow", 1030, 0, 0);
    clear = 1; @(negedge clk); clear = 0;
    check("R7 overflow after clear", overflow, 0);
    check("R7 done after clear", done, 0);

    repeat (5) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule